// File: doc/BRIEF.md
# Reservation Station Group with Result-Bus Snooping

This block is a small pool of reservation stations that sits in front of one pipelined functional unit of an out-of-order core. The issue stage hands it an operation and two source operands. Each operand arrives either as a finished value (tag zero) or as the tag of the producer that will eventually compute it. The operation is parked in the lowest-numbered free station, and the station's own tag is returned so the rename logic can point the destination register at it. When no station is free, issue is refused and the issuing side stalls.

Every station snoops the single shared result bus. A waiting operand whose tag matches the tag on the bus latches that value. A station whose operands are both present competes for the unit, and the oldest such station wins. Its result is computed, carried down a fixed-latency pipeline and offered to the bus.

An arbiter merges this unit's result with a competing result stream from a longer-latency unit, which always has priority. When the unit loses, it freezes its pipeline and holds its result. A station is released in the cycle its result wins the bus.

Top module: `rs_group`

## Requirements
- R1: After reset the bus carries no valid result, and `issueReady` is 1.
- R2: An issue with `issueValid`=1 and `issueReady`=1 fills the lowest-numbered free station. `issueTag` reports that station's tag, which is `TAG_BASE` plus the station index. When all stations are occupied, `issueReady` is 0 and an offered issue has no effect.
- R3: A source tag of 0 means the accompanying value is used as is. A nonzero source tag makes the operand wait.
- R4: A waiting operand latches `busData` in a cycle where `busValid` is 1 and `busTag` equals its tag.
- R5: An operand issued with a nonzero tag that equals the tag on the bus in that same issue cycle takes the bus value at once.
- R6: A station is dispatched only when both operands are present. An operation issued with both operands ready appears on the bus `LAT`+1 cycles after its issue cycle (3 with defaults), carrying the station's tag.
- R7: An operand delivered on the bus in cycle t lets the dependent operation dispatch in cycle t+1, so its result is on the bus in cycle t+1+`LAT`.
- R8: When several stations are ready, the one allocated earliest dispatches first, regardless of station index.
- R9: The external request always wins the bus: `extGrant` follows `extReq`, and the bus then shows `extTag`/`extData`. The unit holds its pending result unchanged and puts it on the bus after the request drops.
- R10: A station is freed in the cycle its result is granted the bus and can be allocated again in the next cycle.
- R11: Opcode `issueOp` selects the result: 0 gives A+B, 1 gives A-B, 2 gives A XOR B, and 3 gives A AND B. All results wrap modulo 2^`DATA_W`.
- R12: At most one producer drives the bus in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request |
| issueOp | input | 2 | Operation code |
| issueTagA | input | TAG_W | Producer tag of operand A, 0 = value valid |
| issueValA | input | DATA_W | Value of operand A |
| issueTagB | input | TAG_W | Producer tag of operand B, 0 = value valid |
| issueValB | input | DATA_W | Value of operand B |
| issueReady | output | 1 | A station is free |
| issueTag | output | TAG_W | Tag of the station that takes the issue |
| extReq | input | 1 | Higher-priority unit offers a result |
| extTag | input | TAG_W | Tag of the external result |
| extData | input | DATA_W | External result value |
| extGrant | output | 1 | External result owns the bus |
| busValid | output | 1 | Result bus carries a value |
| busTag | output | TAG_W | Producer tag on the bus |
| busData | output | DATA_W | Value on the bus |

## Verification
A result whose operands are ready at issue is due on the bus exactly `LAT`+1 cycles after the issue cycle. A dependent operation's result is due `LAT`+1 cycles after the cycle its operand was broadcast. A result held back by the external stream appears in the first cycle the request is low. Each check is placed in the cycle that this counting predicts. The bench drives inputs just after a rising edge and reads outputs at the following falling edge, so a check sees the combinational bus of the current cycle and the registered state of the last edge. Ordering tests record every unit result in arrival order and compare the recorded sequence afterwards.

// File: rtl/rs_group_pkg.sv
package rs_group_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_XOR = 2'd2,
    OP_AND = 2'd3
  } opKind_t;

  // strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic doAlloc;
    logic doDispatch;
    logic doGrant;
    logic advance;
  } rsStrobe_t;

endpackage

// File: rtl/rs_group_dp.sv
module rs_group_dp
  import rs_group_pkg::*;
#(
  parameter int NRS      = 3,
  parameter int LAT      = 2,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 3,
  parameter int TAG_BASE = 1,
  localparam int IDX_W   = (NRS > 1) ? $clog2(NRS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rsStrobe_t         ctl,
  input  logic [IDX_W-1:0]  allocIdx,
  input  logic [IDX_W-1:0]  dispIdx,
  input  logic [1:0]        issueOp,
  input  logic [TAG_W-1:0]  issueTagA,
  input  logic [DATA_W-1:0] issueValA,
  input  logic [TAG_W-1:0]  issueTagB,
  input  logic [DATA_W-1:0] issueValB,
  input  logic              busValid,
  input  logic [TAG_W-1:0]  busTag,
  input  logic [DATA_W-1:0] busData,
  output logic [NRS-1:0]    stBusy,
  output logic [NRS-1:0]    stReady,
  output logic              lastValid,
  output logic [DATA_W-1:0] lastData,
  output logic [TAG_W-1:0]  lastTag
);

  logic [1:0]        opR   [NRS];
  logic [DATA_W-1:0] aVal  [NRS];
  logic [DATA_W-1:0] bVal  [NRS];
  logic [TAG_W-1:0]  aTag  [NRS];
  logic [TAG_W-1:0]  bTag  [NRS];
  logic              aWait [NRS];
  logic              bWait [NRS];
  logic              busyR [NRS];
  logic              execR [NRS];

  logic              pV [LAT];
  logic [DATA_W-1:0] pD [LAT];
  logic [IDX_W-1:0]  pI [LAT];

  function automatic logic [DATA_W-1:0] calc(input logic [1:0] op,
                                             input logic [DATA_W-1:0] a,
                                             input logic [DATA_W-1:0] b);
    case (opKind_t'(op))
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_XOR:  return a ^ b;
      default: return a & b;
    endcase
  endfunction

  for (genvar g = 0; g < NRS; g++) begin : gStation
    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyR[g] <= 1'b0;
        execR[g] <= 1'b0;
        aWait[g] <= 1'b0;
        bWait[g] <= 1'b0;
      end else if (ctl.doGrant && pI[LAT-1] == IDX_W'(g)) begin
        busyR[g] <= 1'b0;
        execR[g] <= 1'b0;
      end else if (ctl.doAlloc && allocIdx == IDX_W'(g)) begin
        busyR[g] <= 1'b1;
        execR[g] <= 1'b0;
        opR[g]   <= issueOp;
        aTag[g]  <= issueTagA;
        bTag[g]  <= issueTagB;
        if (issueTagA == '0) begin
          aVal[g] <= issueValA;  aWait[g] <= 1'b0;
        end else if (busValid && busTag == issueTagA) begin
          aVal[g] <= busData;    aWait[g] <= 1'b0;
        end else begin
          aWait[g] <= 1'b1;
        end
        if (issueTagB == '0) begin
          bVal[g] <= issueValB;  bWait[g] <= 1'b0;
        end else if (busValid && busTag == issueTagB) begin
          bVal[g] <= busData;    bWait[g] <= 1'b0;
        end else begin
          bWait[g] <= 1'b1;
        end
      end else begin
        if (ctl.doDispatch && dispIdx == IDX_W'(g)) execR[g] <= 1'b1;
        if (aWait[g] && busValid && busTag == aTag[g]) begin
          aVal[g] <= busData;  aWait[g] <= 1'b0;
        end
        if (bWait[g] && busValid && busTag == bTag[g]) begin
          bVal[g] <= busData;  bWait[g] <= 1'b0;
        end
      end
    end

    assign stBusy[g]  = busyR[g];
    assign stReady[g] = busyR[g] && !execR[g] && !aWait[g] && !bWait[g];
  end

  // execution pipeline, frozen while the last stage waits for the bus
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pV[0] <= 1'b0;
    end else if (ctl.advance) begin
      pV[0] <= ctl.doDispatch;
      pD[0] <= calc(opR[dispIdx], aVal[dispIdx], bVal[dispIdx]);
      pI[0] <= dispIdx;
    end
  end

  for (genvar k = 1; k < LAT; k++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pV[k] <= 1'b0;
      end else if (ctl.advance) begin
        pV[k] <= pV[k-1];
        pD[k] <= pD[k-1];
        pI[k] <= pI[k-1];
      end
    end
  end

  assign lastValid = pV[LAT-1];
  assign lastData  = pD[LAT-1];
  assign lastTag   = TAG_W'(TAG_BASE) + TAG_W'(pI[LAT-1]);

endmodule

// File: rtl/rs_group_ctrl.sv
module rs_group_ctrl
  import rs_group_pkg::*;
#(
  parameter int NRS    = 3,
  localparam int IDX_W = (NRS > 1) ? $clog2(NRS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NRS-1:0]   stBusy,
  input  logic [NRS-1:0]   stReady,
  input  logic             issueValid,
  input  logic             lastValid,
  input  logic             extReq,
  output rsStrobe_t        ctl,
  output logic [IDX_W-1:0] allocIdx,
  output logic [IDX_W-1:0] dispIdx,
  output logic             issueReady
);

  // older[j][i] set: station j was allocated before station i
  logic [NRS-1:0] older [NRS];

  always_comb begin
    logic found;
    found    = 1'b0;
    allocIdx = '0;
    for (int i = 0; i < NRS; i++) begin
      if (!stBusy[i] && !found) begin
        allocIdx = IDX_W'(i);
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    logic blocked;
    dispIdx = '0;
    for (int i = 0; i < NRS; i++) begin
      blocked = 1'b0;
      for (int j = 0; j < NRS; j++)
        if (stReady[j] && older[j][i]) blocked = 1'b1;
      if (stReady[i] && !blocked) dispIdx = IDX_W'(i);
    end
  end

  assign issueReady     = ~&stBusy;
  assign ctl.doAlloc    = issueValid && issueReady;
  assign ctl.doGrant    = lastValid && !extReq;
  assign ctl.advance    = !lastValid || ctl.doGrant;
  assign ctl.doDispatch = (|stReady) && ctl.advance;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NRS; i++) older[i] <= '0;
    end else if (ctl.doAlloc) begin
      for (int j = 0; j < NRS; j++) begin
        if (IDX_W'(j) == allocIdx) older[j] <= '0;
        else older[j][allocIdx] <= stBusy[j];
      end
    end
  end

endmodule

// File: rtl/rs_group.sv
module rs_group
  import rs_group_pkg::*;
#(
  parameter int NRS      = 3,
  parameter int LAT      = 2,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 3,
  parameter int TAG_BASE = 1,
  localparam int IDX_W   = (NRS > 1) ? $clog2(NRS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [1:0]        issueOp,
  input  logic [TAG_W-1:0]  issueTagA,
  input  logic [DATA_W-1:0] issueValA,
  input  logic [TAG_W-1:0]  issueTagB,
  input  logic [DATA_W-1:0] issueValB,
  output logic              issueReady,
  output logic [TAG_W-1:0]  issueTag,
  input  logic              extReq,
  input  logic [TAG_W-1:0]  extTag,
  input  logic [DATA_W-1:0] extData,
  output logic              extGrant,
  output logic              busValid,
  output logic [TAG_W-1:0]  busTag,
  output logic [DATA_W-1:0] busData
);

  rsStrobe_t         ctl;
  logic [IDX_W-1:0]  allocIdx, dispIdx;
  logic [NRS-1:0]    stBusy, stReady;
  logic              lastValid;
  logic [DATA_W-1:0] lastData;
  logic [TAG_W-1:0]  lastTag;
  logic              unitGrant, doDispatch;

  rs_group_ctrl #(.NRS(NRS)) uCtrl (
    .clk(clk), .rstN(rstN), .stBusy(stBusy), .stReady(stReady),
    .issueValid(issueValid), .lastValid(lastValid), .extReq(extReq),
    .ctl(ctl), .allocIdx(allocIdx), .dispIdx(dispIdx), .issueReady(issueReady)
  );

  rs_group_dp #(.NRS(NRS), .LAT(LAT), .DATA_W(DATA_W), .TAG_W(TAG_W),
                .TAG_BASE(TAG_BASE)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .allocIdx(allocIdx), .dispIdx(dispIdx),
    .issueOp(issueOp), .issueTagA(issueTagA), .issueValA(issueValA),
    .issueTagB(issueTagB), .issueValB(issueValB),
    .busValid(busValid), .busTag(busTag), .busData(busData),
    .stBusy(stBusy), .stReady(stReady),
    .lastValid(lastValid), .lastData(lastData), .lastTag(lastTag)
  );

  assign unitGrant  = ctl.doGrant;
  assign doDispatch = ctl.doDispatch;
  assign extGrant   = extReq;
  assign issueTag   = TAG_W'(TAG_BASE) + TAG_W'(allocIdx);
  assign busValid   = extReq || unitGrant;
  assign busTag     = extReq ? extTag  : lastTag;
  assign busData    = extReq ? extData : lastData;

endmodule

// File: rtl/rs_group_chk.sv
module rs_group_chk #(
  parameter int NRS    = 3,
  parameter int DATA_W = 16,
  localparam int IDX_W = (NRS > 1) ? $clog2(NRS) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              extReq,
  input logic              extGrant,
  input logic              unitGrant,
  input logic              issueReady,
  input logic [NRS-1:0]    stBusy,
  input logic [NRS-1:0]    stReady,
  input logic              doDispatch,
  input logic [IDX_W-1:0]  dispIdx,
  input logic              lastValid,
  input logic [DATA_W-1:0] lastData
);

  // R12
  single_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(extGrant && unitGrant));

  // R9
  held_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastValid && extReq) |=> (lastValid && $stable(lastData)));

  // R2
  full_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !issueReady |-> (&stBusy));

  // R6
  ready_dispatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    doDispatch |-> stReady[dispIdx]);

endmodule

bind rs_group rs_group_chk #(.NRS(NRS), .DATA_W(DATA_W)) uChk (.*);

// File: tb/rs_group_test.sv
module rs_group_test;

  localparam int DATA_W = 16;
  localparam int TAG_W  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0;
  logic [1:0] issueOp = '0;
  logic [TAG_W-1:0] issueTagA = '0, issueTagB = '0;
  logic [DATA_W-1:0] issueValA = '0, issueValB = '0;
  logic issueReady;
  logic [TAG_W-1:0] issueTag;
  logic extReq = 1'b0;
  logic [TAG_W-1:0] extTag = '0;
  logic [DATA_W-1:0] extData = '0;
  logic extGrant, busValid;
  logic [TAG_W-1:0] busTag;
  logic [DATA_W-1:0] busData;

  int checks = 0;
  int errors = 0;
  int gotN = 0;
  logic [DATA_W-1:0] gotD [16];

  // {op, a, b, expected}  (R11)
  localparam logic [49:0] VECS [6] = '{
    {2'd0, 16'h1234, 16'h0101, 16'h1335},
    {2'd1, 16'h0100, 16'h0001, 16'h00FF},
    {2'd2, 16'hFF00, 16'h0FF0, 16'hF0F0},
    {2'd3, 16'hF0F0, 16'h3C3C, 16'h3030},
    {2'd0, 16'hFFFF, 16'h0002, 16'h0001},
    {2'd1, 16'h0000, 16'h0001, 16'hFFFF}
  };

  rs_group uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueOp(issueOp),
    .issueTagA(issueTagA), .issueValA(issueValA),
    .issueTagB(issueTagB), .issueValB(issueValB),
    .issueReady(issueReady), .issueTag(issueTag),
    .extReq(extReq), .extTag(extTag), .extData(extData), .extGrant(extGrant),
    .busValid(busValid), .busTag(busTag), .busData(busData)
  );

  always #5 clk = ~clk;

  // record every result the unit itself places on the bus
  always @(negedge clk) begin
    if (rstN && busValid && !extGrant) begin
      if (gotN < 16) gotD[gotN] = busData;
      gotN = gotN + 1;
    end
  end

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic issue(input logic [1:0] op, input logic [TAG_W-1:0] ta,
                       input logic [DATA_W-1:0] va, input logic [TAG_W-1:0] tb,
                       input logic [DATA_W-1:0] vb);
    issueValid = 1'b1; issueOp = op;
    issueTagA = ta; issueValA = va; issueTagB = tb; issueValB = vb;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual %h expected %h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    idle(3);
    rstN = 1'b1;
    tick();
    @(negedge clk);
    chk(!busValid, "R1 bus idle", busValid, 0);
    chk(issueReady, "R1 ready", issueReady, 1);

    // table walk: R11 operations, R3 immediate operands
    tick();
    gotN = 0;
    for (int i = 0; i < 6; i++) begin
      while (!issueReady) tick();
      issue(VECS[i][49:48], '0, VECS[i][47:32], '0, VECS[i][31:16]);
      tick();
      issueValid = 1'b0;
    end
    idle(12);
    chk(gotN == 6, "R11 count", gotN, 6);
    for (int i = 0; i < 6; i++)
      chk(gotD[i] == VECS[i][15:0], "R11 result", gotD[i], VECS[i][15:0]);

    // R6 latency from issue with ready operands
    issue(2'd0, '0, 16'd1, '0, 16'd2);
    @(negedge clk);
    chk(issueTag == 3'd1, "R2 lowest tag", issueTag, 1);
    chk(!busValid, "R6 not early c0", busValid, 0);
    tick(); issueValid = 1'b0;
    @(negedge clk); chk(!busValid, "R6 not early c1", busValid, 0);
    tick();
    @(negedge clk); chk(!busValid, "R6 not early c2", busValid, 0);
    tick();
    @(negedge clk);
    chk(busValid && busData == 16'd3 && busTag == 3'd1, "R6 due", busData, 3);
    idle(4);

    // R2 full stall, R4 snoop, R10 release timing
    gotN = 0;
    issue(2'd0, '0, 16'd10, 3'd5, '0); tick();
    issue(2'd0, '0, 16'd20, 3'd5, '0); tick();
    issue(2'd0, '0, 16'd30, 3'd5, '0); tick();
    issue(2'd0, '0, 16'd99, '0, '0);
    @(negedge clk); chk(!issueReady, "R2 full", issueReady, 0);
    tick();
    issueValid = 1'b0;
    extReq = 1'b1; extTag = 3'd5; extData = 16'd1;
    @(negedge clk); chk(extGrant && busTag == 3'd5, "R9 ext bus", busTag, 5);
    tick(); extReq = 1'b0;
    @(negedge clk); chk(!issueReady, "R10 still full", issueReady, 0);
    tick(); tick();
    @(negedge clk);
    chk(busData == 16'd11, "R4 captured", busData, 11);
    chk(!issueReady, "R10 not before grant edge", issueReady, 0);
    tick();
    @(negedge clk);
    chk(issueReady && issueTag == 3'd1, "R10 reuse", issueTag, 1);
    chk(busData == 16'd21, "R4 second", busData, 21);
    tick();
    @(negedge clk); chk(busData == 16'd31, "R4 third", busData, 31);
    idle(6);
    chk(gotN == 3, "R2 ignored issue", gotN, 3);

    // R5 same-cycle forwarding at issue
    issue(2'd0, 3'd6, '0, '0, 16'd1);
    extReq = 1'b1; extTag = 3'd6; extData = 16'd7;
    tick(); issueValid = 1'b0; extReq = 1'b0;
    tick(); tick();
    @(negedge clk);
    chk(busValid && busData == 16'd8, "R5 forward", busData, 8);
    idle(4);

    // R7 dependent dispatch timing
    issue(2'd0, '0, 16'd1, '0, 16'd1); tick();
    issue(2'd0, 3'd1, '0, '0, 16'd5); tick();
    issueValid = 1'b0; tick();
    @(negedge clk); chk(busData == 16'd2, "R7 producer", busData, 2);
    tick(); tick();
    @(negedge clk); chk(!busValid, "R7 not early", busValid, 0);
    tick();
    @(negedge clk);
    chk(busValid && busData == 16'd7, "R7 dependent", busData, 7);
    idle(4);

    // R8 oldest ready first
    gotN = 0;
    issue(2'd0, '0, 16'd100, 3'd5, '0); tick();
    issue(2'd0, '0, 16'd200, '0, '0); tick();
    issue(2'd0, '0, 16'd300, 3'd5, '0); tick();
    issueValid = 1'b0; tick(); tick();
    issue(2'd0, '0, 16'd400, 3'd5, '0);
    @(negedge clk); chk(issueTag == 3'd2, "R10 middle reuse", issueTag, 2);
    tick();
    issueValid = 1'b0;
    extReq = 1'b1; extTag = 3'd5; extData = 16'd1;
    tick(); extReq = 1'b0;
    idle(10);
    chk(gotN == 4, "R8 count", gotN, 4);
    chk(gotD[1] == 16'd101, "R8 first", gotD[1], 101);
    chk(gotD[2] == 16'd301, "R8 second", gotD[2], 301);
    chk(gotD[3] == 16'd401, "R8 third", gotD[3], 401);

    // R9 external priority and hold, R12 one owner
    issue(2'd0, '0, 16'd5, '0, 16'd5); tick();
    issueValid = 1'b0; tick(); tick();
    extReq = 1'b1; extTag = 3'd6; extData = 16'h0077;
    @(negedge clk);
    chk(extGrant && busTag == 3'd6 && busData == 16'h0077, "R9 ext wins", busData, 16'h77);
    tick();
    @(negedge clk); chk(busData == 16'h0077, "R12 still ext", busData, 16'h77);
    tick(); extReq = 1'b0;
    @(negedge clk);
    chk(busValid && busData == 16'd10 && busTag == 3'd1, "R9 held result", busData, 10);
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule